// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the target side of a three-wire serial memory bus. A host raises chip select, toggles a serial clock and shifts a frame into the data input on rising clock edges. The frame opens with a start bit and carries a two-bit opcode, a word address and, for store commands, one data word. The engine decodes the frame and does one of three things: it streams a stored word back on the data output, it changes the write-enable latch, or it arms a programming job. An armed job begins when chip select falls.

Programming is self-timed and lasts a fixed number of system clocks, set by a parameter. Every kind of job is gated by the write-enable latch. The latch is clear after reset and changes only when an enable or disable command is decoded. While a job runs, any new frame is ignored.

If the host raises chip select during the job, the data output reports busy (0) and then ready (1). The host can dismiss this indication with a rising serial clock while chip select and data input are both high. All three bus pins are sampled by synchronisers into the system clock domain. The word array is a plain dual-port memory, so an FPGA can map it onto block RAM.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, so a store or erase command sent before any enable command leaves memory unchanged, and the data output is 0.
- R2: Word store (opcode 01), word erase (opcode 11), fill-all and erase-all change memory only while the write-enable latch is set.
- R3: The enable command (opcode 00, top two address bits 11) sets the latch and the disable command (opcode 00, top two address bits 00) clears it. The latch stays set across any number of programming jobs.
- R4: A frame is a start bit of 1, then the opcode MSB first, then ADDR_W address bits MSB first, then WORD_W data bits MSB first for word store and fill-all. Zeros clocked in before the start bit are ignored.
- R5: For a read (opcode 10) the output is 0 right after the last address bit. Each later rising serial clock then presents the next bit of the addressed word, MSB first.
- R6: An armed job starts on the falling edge of chip select. A further rising serial clock after the last frame bit and before chip select falls cancels the job.
- R7: With chip select high during a job the data output is 0. With chip select still high after the job has ended it is 1.
- R8: A rising serial clock with chip select and data input both high clears the ready/busy indication, after which the output stays 0.
- R9: If chip select rises only after the job has already ended, the output is 0 (no status).
- R10: Word erase sets every bit of the addressed word to 1. Erase-all (opcode 00, top address bits 10) sets every word to all ones.
- R11: Fill-all (opcode 00, top address bits 01) writes its data word into every address.
- R12: A frame shifted in while a job is running has no effect.
- R13: While chip select is low the data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sk | input | 1 | Serial bus clock, sampled by clk |
| cs | input | 1 | Chip select, active high |
| din | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data / ready-busy out, registered |

## Verification
The status-dismiss gesture and the start bit of the next frame are the same thing: one rising serial clock with chip select and data input high. Both therefore land on a single clock edge. The bench provokes this after a job has reported ready. It clocks a 1 with chip select held high and expects the output to fall to 0 at once, with no stale ready bit. It then drops chip select so the half-started frame is discarded, and a later read confirms that memory holds the value the job wrote.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_ARMED,
    ST_DISCARD
  } dec_state_t;

  typedef enum logic [1:0] {
    PG_WORD,
    PG_WIPE,
    PG_FILL,
    PG_WIPE_ALL
  } prog_kind_t;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WIPE  = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPEALL = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], pin_i};
  end

  assign level_o = chain[STAGES-1];

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sk_rise,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              din_lvl,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              reading,
  output logic              rd_bit,
  output logic              wen,
  output logic              start,
  output prog_kind_t        start_kind,
  output logic [ADDR_W-1:0] start_addr,
  output logic [WORD_W-1:0] start_data
);

  localparam int LONGEST = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  dec_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] data;
  prog_kind_t        kind;
  logic [ADDR_W-1:0] addr_next;
  logic [1:0]        sub_code;
  logic [WORD_W-1:0] rd_shift;

  always_comb begin
    addr_next = {addr[ADDR_W-2:0], din_lvl};
    sub_code  = addr_next[ADDR_W-1 -: 2];
    rd_shift  = rd_q << cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op      <= '0;
      addr    <= '0;
      data    <= '0;
      kind    <= PG_WORD;
      wen     <= 1'b0;
      start   <= 1'b0;
      rd_bit  <= 1'b0;
      rd_addr <= '0;
    end else begin
      start <= 1'b0;
      if (cs_fall) begin
        if (state == ST_ARMED && wen) start <= 1'b1;
        state  <= ST_IDLE;
        cnt    <= '0;
        rd_bit <= 1'b0;
      end else if (sk_rise && cs_lvl) begin
        case (state)
          ST_IDLE: begin
            if (!busy && din_lvl) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            op <= {op[0], din_lvl};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr <= addr_next;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              case (op)
                OP_READ: begin
                  rd_addr <= addr_next;
                  rd_bit  <= 1'b0;
                  state   <= ST_READ;
                end
                OP_STORE: begin
                  kind  <= PG_WORD;
                  state <= ST_DATA;
                end
                OP_WIPE: begin
                  kind  <= PG_WIPE;
                  state <= ST_ARMED;
                end
                default: begin
                  case (sub_code)
                    SUB_UNLOCK: begin
                      wen   <= 1'b1;
                      state <= ST_DISCARD;
                    end
                    SUB_LOCK: begin
                      wen   <= 1'b0;
                      state <= ST_DISCARD;
                    end
                    SUB_WIPEALL: begin
                      kind  <= PG_WIPE_ALL;
                      state <= ST_ARMED;
                    end
                    default: begin
                      kind  <= PG_FILL;
                      state <= ST_DATA;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            data <= {data[WORD_W-2:0], din_lvl};
            if (cnt == CNT_W'(WORD_W - 1)) begin
              cnt   <= '0;
              state <= ST_ARMED;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (cnt < CNT_W'(WORD_W)) begin
              rd_bit <= rd_shift[WORD_W-1];
              cnt    <= cnt + 1'b1;
            end else begin
              rd_bit <= 1'b0;
            end
          end
          ST_ARMED: state <= ST_DISCARD;
          default:  state <= state;
        endcase
      end
    end
  end

  assign reading    = (state == ST_READ);
  assign start_kind = kind;
  assign start_addr = addr;
  assign start_data = data;

endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int WORD_W     = 16,
  parameter int TWP_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  prog_kind_t        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [WORD_W-1:0] wdata
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int IDX_W = ADDR_W + 1;
  localparam int TMR_W = $clog2(TWP_CYCLES + 1);

  logic [TMR_W-1:0]  tmr;
  logic [IDX_W-1:0]  idx;
  prog_kind_t        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              bulk;

  always_comb begin
    bulk  = (kind_q == PG_FILL) || (kind_q == PG_WIPE_ALL);
    we    = busy && (bulk ? (idx < IDX_W'(WORDS)) : (idx == '0));
    waddr = bulk ? idx[ADDR_W-1:0] : addr_q;
    wdata = ((kind_q == PG_WIPE) || (kind_q == PG_WIPE_ALL)) ? '1 : data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tmr    <= '0;
      idx    <= '0;
      kind_q <= PG_WORD;
      addr_q <= '0;
      data_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      tmr    <= TMR_W'(TWP_CYCLES - 1);
      idx    <= '0;
      kind_q <= kind;
      addr_q <= addr;
      data_q <= data;
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
      if (we) idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int WORD_W      = 16,
  parameter int TWP_CYCLES  = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sk,
  input  logic cs,
  input  logic din,
  output logic dout
);

  logic sk_lvl, cs_lvl, din_lvl;
  logic sk_prev, cs_prev, busy_prev;
  logic sk_rise, cs_fall, busy_fall;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sk  (.clk(clk), .rst(rst), .pin_i(sk),  .level_o(sk_lvl));
  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_cs  (.clk(clk), .rst(rst), .pin_i(cs),  .level_o(cs_lvl));
  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_din (.clk(clk), .rst(rst), .pin_i(din), .level_o(din_lvl));

  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_q;
  logic              reading, rd_bit, wen, prog_start, busy;
  prog_kind_t        start_kind;
  logic [ADDR_W-1:0] start_addr;
  logic [WORD_W-1:0] start_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;
  logic              status_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_prev   <= 1'b0;
      cs_prev   <= 1'b0;
      busy_prev <= 1'b0;
    end else begin
      sk_prev   <= sk_lvl;
      cs_prev   <= cs_lvl;
      busy_prev <= busy;
    end
  end

  assign sk_rise   = sk_lvl & ~sk_prev;
  assign cs_fall   = ~cs_lvl & cs_prev;
  assign busy_fall = ~busy & busy_prev;

  mw_cmd_decoder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst(rst), .sk_rise(sk_rise), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .din_lvl(din_lvl), .busy(busy), .rd_q(rd_q), .rd_addr(rd_addr),
    .reading(reading), .rd_bit(rd_bit), .wen(wen), .start(prog_start),
    .start_kind(start_kind), .start_addr(start_addr), .start_data(start_data)
  );

  mw_prog_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TWP_CYCLES(TWP_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start(prog_start), .kind(start_kind), .addr(start_addr),
    .data(start_data), .busy(busy), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                                 status_en <= 1'b0;
    else if (prog_start)                     status_en <= 1'b1;
    else if (sk_rise && cs_lvl && din_lvl)   status_en <= 1'b0;
    else if (cs_fall && !busy)               status_en <= 1'b0;
    else if (busy_fall && !cs_lvl)           status_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= cs_lvl & (reading ? rd_bit : (status_en & ~busy));
  end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_lvl,
  input logic dout,
  input logic busy,
  input logic we,
  input logic wen,
  input logic start
);

  p_write_gated_r2: assert property (@(posedge clk) disable iff (rst)
    we |-> wen);

  p_job_runs_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  p_no_restart_r12: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  p_quiet_deselect_r13: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> !dout);

  p_busy_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && busy) |=> !dout);

  p_latch_held_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wen));

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .dout(dout), .busy(busy),
  .we(mem_we), .wen(wen), .start(prog_start)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int WW   = 16;
  localparam int TWP  = 400;
  localparam int HALF = 6;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sk = 1'b0, cs = 1'b0, din = 1'b0;
  logic dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .WORD_W(WW), .TWP_CYCLES(TWP)) dut (
    .clk(clk), .rst(rst), .sk(sk), .cs(cs), .din(din), .dout(dout)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [WW-1:0] model [NW];
  bit model_wen = 0;

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    din = b; tick(HALF);
    sk = 1'b1; tick(HALF);
    sk = 1'b0;
  endtask

  task automatic begin_cmd;
    cs = 1'b1; tick(HALF);
  endtask

  task automatic end_cmd;
    din = 1'b0; tick(HALF);
    cs = 1'b0; tick(2*HALF);
  endtask

  task automatic send_head(input logic [1:0] op, input logic [AW-1:0] a);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = AW-1; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_word(input logic [WW-1:0] d);
    for (int i = WW-1; i >= 0; i--) sk_bit(d[i]);
  endtask

  function automatic logic [AW-1:0] sub_addr(input logic [1:0] s);
    return {s, {(AW-2){1'b0}}};
  endfunction

  task automatic do_misc(input logic [1:0] s);
    begin_cmd; send_head(2'b00, sub_addr(s)); end_cmd;
    if (s == 2'b11) model_wen = 1;
    if (s == 2'b00) model_wen = 0;
  endtask

  task automatic wait_prog;
    tick(TWP + 20);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
    begin_cmd; send_head(2'b01, a); send_word(d); end_cmd; wait_prog;
    if (model_wen) model[a] = d;
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    begin_cmd; send_head(2'b11, a); end_cmd; wait_prog;
    if (model_wen) model[a] = '1;
  endtask

  task automatic do_eral;
    begin_cmd; send_head(2'b00, sub_addr(2'b10)); end_cmd; wait_prog;
    if (model_wen) for (int i = 0; i < NW; i++) model[i] = '1;
  endtask

  task automatic do_wrall(input logic [WW-1:0] d);
    begin_cmd; send_head(2'b00, sub_addr(2'b01)); send_word(d); end_cmd; wait_prog;
    if (model_wen) for (int i = 0; i < NW; i++) model[i] = d;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input int lead);
    logic [WW-1:0] got;
    begin_cmd;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    send_head(2'b10, a);
    tick(4);
    chk({req, " R5 dummy"}, {{(WW-1){1'b0}}, dout}, '0);
    for (int i = WW-1; i >= 0; i--) begin
      sk_bit(1'b0); tick(4);
      got[i] = dout;
    end
    chk(req, got, model[a]);
    end_cmd;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < NW; i++) read_check(req, AW'(i), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(5); rst = 1'b0; tick(5);

    // R13: deselected output low
    chk("R13 idle", {{(WW-1){1'b0}}, dout}, '0);
    // R1: no status after reset with cs high
    cs = 1'b1; tick(HALF);
    chk("R1 dout after reset", {{(WW-1){1'b0}}, dout}, '0);
    cs = 1'b0; tick(HALF);

    // Bring memory to a known state
    do_misc(2'b11);
    do_eral;
    read_all("R10 erase-all");

    // R11: fill-all
    do_wrall(16'hA55A);
    read_all("R11 fill-all");

    // R1: reset clears latch; store ignored
    rst = 1'b1; tick(3); rst = 1'b0; tick(3);
    model_wen = 0;
    do_write(4'd3, 16'h1234);
    read_check("R1 store after reset", 4'd3, 0);

    // R2: locked, every job ignored
    do_erase(4'd4);
    do_eral;
    do_wrall(16'h0F0F);
    read_check("R2 locked erase", 4'd4, 0);
    read_check("R2 locked bulk", 4'd9, 0);

    // R3: unlock persists over several jobs
    do_misc(2'b11);
    do_write(4'd1, 16'hBEEF);
    do_write(4'd2, 16'hCAFE);
    read_check("R3 first job", 4'd1, 0);
    read_check("R3 second job", 4'd2, 0);

    // R10: single word erase
    do_erase(4'd2);
    read_check("R10 word erase", 4'd2, 0);

    // R4: leading zeros before start bit
    read_check("R4 leading zeros", 4'd1, 3);

    // R6: extra clock before deselect cancels job
    begin_cmd; send_head(2'b01, 4'd5); send_word(16'h7777); sk_bit(1'b0); end_cmd; wait_prog;
    read_check("R6 cancel", 4'd5, 0);

    // R7 / R8: status while selected, then dismiss
    begin_cmd; send_head(2'b01, 4'd6); send_word(16'h6006); end_cmd;
    model[6] = 16'h6006;
    cs = 1'b1; tick(HALF);
    chk("R7 busy", {{(WW-1){1'b0}}, dout}, '0);
    tick(TWP);
    chk("R7 ready", {{(WW-1){1'b0}}, dout}, 16'h0001);
    sk_bit(1'b1); tick(4);
    chk("R8 dismissed", {{(WW-1){1'b0}}, dout}, '0);
    cs = 1'b0; tick(2*HALF);
    read_check("R8 data kept", 4'd6, 0);

    // R9: select only after job finished
    begin_cmd; send_head(2'b01, 4'd7); send_word(16'h7007); end_cmd;
    model[7] = 16'h7007;
    tick(TWP + 20);
    cs = 1'b1; tick(HALF);
    chk("R9 no status", {{(WW-1){1'b0}}, dout}, '0);
    cs = 1'b0; tick(2*HALF);

    // R12: lock command during a job is ignored
    begin_cmd; send_head(2'b01, 4'd8); send_word(16'h8008); end_cmd;
    model[8] = 16'h8008;
    begin_cmd; send_head(2'b00, sub_addr(2'b00)); end_cmd;
    wait_prog;
    do_write(4'd10, 16'hA0A0);
    read_check("R12 lock ignored", 4'd10, 0);
    read_check("R12 prior job", 4'd8, 0);

    // R3: disable clears latch
    do_misc(2'b00);
    do_write(4'd10, 16'h0000);
    read_check("R3 locked again", 4'd10, 0);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      int sel;
      logic [AW-1:0] a;
      logic [WW-1:0] d;
      sel = int'($urandom % 5);
      a = AW'($urandom);
      d = WW'($urandom);
      case (sel)
        0: do_misc(2'b11);
        1: do_misc(2'b00);
        2: do_write(a, d);
        3: do_erase(a);
        default: read_check("R2 random", a, int'($urandom % 3));
      endcase
    end
    read_all("R4 final sweep");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule